// File: doc/BRIEF.md
# Quarter-Rate Wavefront Vector ALU

This block is one SIMD vector unit that executes 64-lane wavefront instructions on only 16 physical lanes. Each instruction is split into four lane groups. Group 0 holds lanes 0-15, group 1 lanes 16-31, group 2 lanes 32-47 and group 3 lanes 48-63. One group enters a four-stage pipeline per cycle. A per-lane vector register file sits inside the block. Operands are read for a group in stage 0, and its result is written back at the end of stage 3.

A new instruction is taken once every four cycles, in the slot where its group 0 enters stage 0. A group's result is committed before the next instruction reads that same group. A chain of instructions that each read the previous result can therefore issue in every slot, with no stall and no bypass network. The four-cycle read-after-write latency is hidden by the group rotation.

An integer add with carry also collects one carry bit per lane into a 64-bit mask. That mask is offered on a scalar-write request port as a single-cycle strobe once all four groups have finished. Arithmetic is plain 32-bit two's-complement wrap-around; numeric formats beyond that are outside this block.

Top module: `vq_wave_alu`

## Requirements
- R1: `in_ready` is high in exactly one cycle of every four. The first such cycle is the first cycle after reset is released. An instruction is accepted when `in_valid` and `in_ready` are both high in a cycle.
- R2: The results of one instruction appear on the writeback port in group order 0, 1, 2, 3 on consecutive cycles. `wb_group` carries the group number, and group g carries lanes 16g to 16g+15, with lane 16g+i in bits [32i+31:32i] of `wb_data`.
- R3: For an instruction accepted in cycle T, group g is shown on the writeback port in cycle T+3+g and is committed to the register file at the end of that cycle.
- R4: Instructions that read the register written by the instruction just before them may issue in every accept slot. Each one sees the fully updated value, including a chain of v = v*v + v on one register.
- R5: Opcode 0 (seed) writes imm + lane index (0 to 63) into each lane of the destination register.
- R6: Opcode 1 (add) writes src0 + src1 modulo 2^32 per lane.
- R7: Opcode 2 (multiply-add) writes the low 32 bits of src0*src1 + src2 per lane.
- R8: Opcode 3 (add with carry) writes src0 + src1 modulo 2^32 per lane. Bit i of `sc_mask` is the carry out of lane i. `sc_valid` is high for exactly one cycle, T+7, with `sc_dst` equal to the instruction's scalar destination.
- R9: Opcodes 0, 1 and 2 never raise `sc_valid`.
- R10: `in_valid` in a cycle where `in_ready` is low is ignored: no writeback follows and no register changes. An accept slot with `in_valid` low produces no writeback either.
- R11: While reset is high, `in_ready`, `wb_valid` and `sc_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Accept slot (group-0 slot) |
| in_op | input | 2 | Opcode: 0 seed, 1 add, 2 multiply-add, 3 add with carry |
| in_vdst | input | 3 | Destination vector register |
| in_vsrc0 | input | 3 | First source vector register |
| in_vsrc1 | input | 3 | Second source vector register |
| in_vsrc2 | input | 3 | Third source vector register (multiply-add addend) |
| in_sdst | input | 4 | Scalar destination for the carry mask |
| in_imm | input | 32 | Immediate for seed |
| wb_valid | output | 1 | Writeback of one lane group this cycle |
| wb_group | output | 2 | Lane group being written |
| wb_vdst | output | 3 | Register being written |
| wb_data | output | 512 | 16 lane results of the group |
| sc_valid | output | 1 | Scalar-write request strobe |
| sc_dst | output | 4 | Scalar register to write |
| sc_mask | output | 64 | Per-lane carry mask |

## Verification
Group g of an instruction accepted in cycle T is due on the writeback port in cycle T+3+g, and a carry mask is due in cycle T+7. The driver records T at the acceptance edge and stores the due cycle with each expected item in the scoreboard. The monitor samples on the falling edge and compares the cycle number as well as the group, register and data. A result that comes early, late, unasked for or not at all is therefore reported. Back-to-back dependent chains confirm that each read falls after the matching write, because the reference model updates its registers in issue order.

// File: rtl/vq_pkg.sv
package vq_pkg;

    localparam int DW     = 32;
    localparam int QL     = 16;
    localparam int NGROUP = 4;
    localparam int NVREG  = 8;
    localparam int NSREG  = 16;
    localparam int WAVE   = QL * NGROUP;
    localparam int VAW    = $clog2(NVREG);
    localparam int SAW    = $clog2(NSREG);
    localparam int GAW    = $clog2(NGROUP);
    localparam int LAW    = $clog2(QL);
    localparam int LIW    = GAW + LAW;
    localparam int GW     = QL * DW;

    typedef enum logic [1:0] {
        OP_SEED = 2'd0,
        OP_ADD  = 2'd1,
        OP_MAD  = 2'd2,
        OP_ADDC = 2'd3
    } vop_e;

    typedef logic [GW-1:0] grp_data_t;
    typedef logic [QL-1:0] grp_mask_t;

    typedef struct packed {
        vop_e           op;
        logic [VAW-1:0] vdst;
        logic [VAW-1:0] vsrc0;
        logic [VAW-1:0] vsrc1;
        logic [VAW-1:0] vsrc2;
        logic [SAW-1:0] sdst;
        logic [DW-1:0]  imm;
    } vinstr_t;

    typedef struct packed {
        logic           valid;
        vop_e           op;
        logic [VAW-1:0] vdst;
        logic [SAW-1:0] sdst;
        logic [GAW-1:0] grp;
    } vctl_t;

    // One lane of arithmetic: bit DW is the carry out (add with carry only).
    function automatic logic [DW:0] lane_calc(vop_e op, logic [DW-1:0] a, logic [DW-1:0] b,
                                             logic [DW-1:0] c, logic [DW-1:0] imm,
                                             logic [LIW-1:0] lane);
        logic [DW:0] r;
        case (op)
            OP_SEED: r = {1'b0, imm + DW'(lane)};
            OP_ADD:  r = {1'b0, a + b};
            OP_MAD:  r = {1'b0, DW'(a * b) + c};
            default: r = {1'b0, a} + {1'b0, b};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/vq_vrf.sv
module vq_vrf
    import vq_pkg::*;
(
    input  logic                 clk,
    input  logic [GAW-1:0]       rd_grp,
    input  logic [2:0][VAW-1:0]  rd_addr,
    output grp_data_t [2:0]      rd_data,
    input  logic                 wr_en,
    input  logic [GAW-1:0]       wr_grp,
    input  logic [VAW-1:0]       wr_addr,
    input  grp_data_t            wr_data
);
    localparam int ROWS = NVREG * NGROUP;

    // One row holds one lane group of one register.
    grp_data_t mem [ROWS];

    for (genvar p = 0; p < 3; p++) begin : g_rd
        assign rd_data[p] = mem[{rd_addr[p], rd_grp}];
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[{wr_addr, wr_grp}] <= wr_data;
        end
    end
endmodule

// File: rtl/vq_lane_alu.sv
module vq_lane_alu
    import vq_pkg::*;
(
    input  vop_e            op,
    input  logic [GAW-1:0]  grp,
    input  logic [DW-1:0]   imm,
    input  grp_data_t       src_a,
    input  grp_data_t       src_b,
    input  grp_data_t       src_c,
    output grp_data_t       res,
    output grp_mask_t       carry
);
    for (genvar i = 0; i < QL; i++) begin : g_lane
        logic [LIW-1:0] lidx;
        logic [DW:0]    out;
        assign lidx = {grp, LAW'(i)};
        assign out  = lane_calc(op, src_a[i*DW +: DW], src_b[i*DW +: DW],
                                src_c[i*DW +: DW], imm, lidx);
        assign res[i*DW +: DW] = out[DW-1:0];
        assign carry[i]        = out[DW];
    end
endmodule

// File: rtl/vq_carry_gather.sv
module vq_carry_gather
    import vq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cy_valid,
    input  logic [GAW-1:0]    cy_grp,
    input  logic [SAW-1:0]    cy_sdst,
    input  grp_mask_t         cy_bits,
    output logic              sc_valid,
    output logic [SAW-1:0]    sc_sdst,
    output logic [WAVE-1:0]   sc_mask
);
    logic [WAVE-1:0] acc, acc_n;

    always_comb begin
        acc_n = acc;
        acc_n[int'(cy_grp) * QL +: QL] = cy_bits;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc      <= '0;
            sc_valid <= 1'b0;
            sc_sdst  <= '0;
            sc_mask  <= '0;
        end else begin
            sc_valid <= 1'b0;
            if (cy_valid) begin
                acc <= acc_n;
                if (cy_grp == GAW'(NGROUP - 1)) begin
                    sc_valid <= 1'b1;
                    sc_sdst  <= cy_sdst;
                    sc_mask  <= acc_n;
                end
            end
        end
    end
endmodule

// File: rtl/vq_wave_alu.sv
module vq_wave_alu
    import vq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [1:0]        in_op,
    input  logic [VAW-1:0]    in_vdst,
    input  logic [VAW-1:0]    in_vsrc0,
    input  logic [VAW-1:0]    in_vsrc1,
    input  logic [VAW-1:0]    in_vsrc2,
    input  logic [SAW-1:0]    in_sdst,
    input  logic [DW-1:0]     in_imm,
    output logic              wb_valid,
    output logic [GAW-1:0]    wb_group,
    output logic [VAW-1:0]    wb_vdst,
    output logic [GW-1:0]     wb_data,
    output logic              sc_valid,
    output logic [SAW-1:0]    sc_dst,
    output logic [WAVE-1:0]   sc_mask
);
    // Stage 0 slot counter: the value equals the lane group now reading.
    logic [GAW-1:0] phase;
    vinstr_t        in_instr, hold_instr, s0_instr;
    logic           hold_valid, s0_valid;

    assign in_instr = '{op: vop_e'(in_op), vdst: in_vdst, vsrc0: in_vsrc0, vsrc1: in_vsrc1,
                        vsrc2: in_vsrc2, sdst: in_sdst, imm: in_imm};

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else begin
            phase <= phase + GAW'(1);
        end
    end

    assign in_ready = !rst && (phase == '0);

    // Hold the accepted descriptor for groups 1..NGROUP-1.
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_valid <= 1'b0;
            hold_instr <= '0;
        end else if (phase == '0) begin
            hold_valid <= in_valid;
            hold_instr <= in_instr;
        end
    end

    assign s0_valid = (phase == '0) ? in_valid : hold_valid;
    assign s0_instr = (phase == '0) ? in_instr : hold_instr;

    // Register file: read in stage 0, write at end of stage 3.
    logic [2:0][VAW-1:0] rd_addr;
    grp_data_t [2:0]     rd_data;
    vctl_t               p1_ctl, p2_ctl, p3_ctl;
    grp_data_t [2:0]     p1_opnd;
    logic [DW-1:0]       p1_imm;
    grp_data_t           alu_res, p2_res, p3_res;
    grp_mask_t           alu_cy, p2_cy, p3_cy;

    assign rd_addr[0] = s0_instr.vsrc0;
    assign rd_addr[1] = s0_instr.vsrc1;
    assign rd_addr[2] = s0_instr.vsrc2;

    vq_vrf u_vrf (
        .clk     (clk),
        .rd_grp  (phase),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .wr_en   (p3_ctl.valid),
        .wr_grp  (p3_ctl.grp),
        .wr_addr (p3_ctl.vdst),
        .wr_data (p3_res)
    );

    // Stage 1 register: operands captured from the file.
    always_ff @(posedge clk) begin
        if (rst) begin
            p1_ctl  <= '0;
            p1_opnd <= '0;
            p1_imm  <= '0;
        end else begin
            p1_ctl  <= '{valid: s0_valid, op: s0_instr.op, vdst: s0_instr.vdst,
                         sdst: s0_instr.sdst, grp: phase};
            p1_opnd <= rd_data;
            p1_imm  <= s0_instr.imm;
        end
    end

    vq_lane_alu u_alu (
        .op    (p1_ctl.op),
        .grp   (p1_ctl.grp),
        .imm   (p1_imm),
        .src_a (p1_opnd[0]),
        .src_b (p1_opnd[1]),
        .src_c (p1_opnd[2]),
        .res   (alu_res),
        .carry (alu_cy)
    );

    // Stages 2 and 3 carry the result towards writeback.
    always_ff @(posedge clk) begin
        if (rst) begin
            p2_ctl <= '0;
            p2_res <= '0;
            p2_cy  <= '0;
            p3_ctl <= '0;
            p3_res <= '0;
            p3_cy  <= '0;
        end else begin
            p2_ctl <= p1_ctl;
            p2_res <= alu_res;
            p2_cy  <= alu_cy;
            p3_ctl <= p2_ctl;
            p3_res <= p2_res;
            p3_cy  <= p2_cy;
        end
    end

    assign wb_valid = p3_ctl.valid;
    assign wb_group = p3_ctl.grp;
    assign wb_vdst  = p3_ctl.vdst;
    assign wb_data  = p3_res;

    vq_carry_gather u_gather (
        .clk      (clk),
        .rst      (rst),
        .cy_valid (p3_ctl.valid && (p3_ctl.op == OP_ADDC)),
        .cy_grp   (p3_ctl.grp),
        .cy_sdst  (p3_ctl.sdst),
        .cy_bits  (p3_cy),
        .sc_valid (sc_valid),
        .sc_sdst  (sc_dst),
        .sc_mask  (sc_mask)
    );
endmodule

// File: rtl/vq_wave_alu_chk.sv
module vq_wave_alu_chk
    import vq_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           in_valid,
    input logic           in_ready,
    input logic           wb_valid,
    input logic [GAW-1:0] wb_group,
    input logic           sc_valid
);
    logic [GAW-1:0] slot;

    always_ff @(posedge clk) begin
        if (rst) slot <= '0;
        else     slot <= slot + GAW'(1);
    end

    // R1
    ready_cadence_chk: assert property (@(posedge clk) disable iff (rst)
        in_ready == (slot == '0));

    // R3
    issue_to_wb_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> ##2 (wb_valid && wb_group == '0));

    // R2
    group_step_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && wb_group != GAW'(NGROUP - 1)) |=>
            (wb_valid && wb_group == GAW'($past(wb_group) + GAW'(1))));

    // R10
    no_wb_without_issue_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && wb_group == '0) |-> $past(in_valid && in_ready, 3));

    // R8
    mask_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        sc_valid |-> ($past(wb_valid) && $past(wb_group) == GAW'(NGROUP - 1)));

    // R8
    mask_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        sc_valid |=> !sc_valid);
endmodule

bind vq_wave_alu vq_wave_alu_chk u_vq_wave_alu_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .wb_valid (wb_valid),
    .wb_group (wb_group),
    .sc_valid (sc_valid)
);

// File: tb/test_vq_wave_alu.sv
module test_vq_wave_alu;
    import vq_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [1:0]        in_op = '0;
    logic [VAW-1:0]    in_vdst = '0, in_vsrc0 = '0, in_vsrc1 = '0, in_vsrc2 = '0;
    logic [SAW-1:0]    in_sdst = '0;
    logic [DW-1:0]     in_imm = '0;
    logic              wb_valid;
    logic [GAW-1:0]    wb_group;
    logic [VAW-1:0]    wb_vdst;
    logic [GW-1:0]     wb_data;
    logic              sc_valid;
    logic [SAW-1:0]    sc_dst;
    logic [WAVE-1:0]   sc_mask;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vq_wave_alu i_vq_wave_alu (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
        .in_vdst(in_vdst), .in_vsrc0(in_vsrc0), .in_vsrc1(in_vsrc1), .in_vsrc2(in_vsrc2),
        .in_sdst(in_sdst), .in_imm(in_imm), .wb_valid(wb_valid), .wb_group(wb_group),
        .wb_vdst(wb_vdst), .wb_data(wb_data), .sc_valid(sc_valid), .sc_dst(sc_dst),
        .sc_mask(sc_mask)
    );

    typedef struct {
        int        due;
        int        grp;
        int        dst;
        grp_data_t data;
        string     tag;
    } wb_exp_t;

    typedef struct {
        int              due;
        int              dst;
        logic [WAVE-1:0] mask;
        string           tag;
    } sc_exp_t;

    wb_exp_t       wq[$];
    sc_exp_t       sq[$];
    logic [DW-1:0] mdl [NVREG][WAVE];
    int            cyc = 0;
    int            checks = 0;
    int            errors = 0;
    int            stray_sc = 0;
    bit            mon_on = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(bit ok, string tag, string what, logic [GW-1:0] got, logic [GW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    // Scoreboard monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (mon_on) begin
            if (wb_valid) begin
                if (wq.size() == 0) begin
                    chk(1'b0, "R10", "writeback with nothing issued", GW'(wb_vdst), '0);
                end else begin
                    wb_exp_t e;
                    e = wq.pop_front();
                    chk(e.due == cyc, "R3", "writeback cycle", GW'(cyc), GW'(e.due));
                    chk(int'(wb_group) == e.grp, "R2", "group", GW'(wb_group), GW'(e.grp));
                    chk(int'(wb_vdst) == e.dst, e.tag, "dest reg", GW'(wb_vdst), GW'(e.dst));
                    chk(wb_data == e.data, e.tag, "lane data", wb_data, e.data);
                end
            end else if (wq.size() > 0 && wq[0].due <= cyc) begin
                chk(1'b0, wq[0].tag, "missing writeback", '0, GW'(wq[0].due));
                void'(wq.pop_front());
            end
            if (sc_valid) begin
                if (sq.size() == 0) begin
                    stray_sc++;
                    chk(1'b0, "R9", "scalar request with no carry op", GW'(sc_mask), '0);
                end else begin
                    sc_exp_t s;
                    s = sq.pop_front();
                    chk(s.due == cyc, "R8", "mask cycle", GW'(cyc), GW'(s.due));
                    chk(int'(sc_dst) == s.dst, "R8", "scalar dest", GW'(sc_dst), GW'(s.dst));
                    chk(sc_mask == s.mask, s.tag, "carry mask", GW'(sc_mask), GW'(s.mask));
                end
            end else if (sq.size() > 0 && sq[0].due <= cyc) begin
                chk(1'b0, "R8", "missing scalar request", '0, GW'(sq[0].due));
                void'(sq.pop_front());
            end
        end
    end

    // Driver: waits for the accept slot, drives one cycle, queues expectations.
    task automatic issue(vop_e op, int d, int s0, int s1, int s2, int sd,
                         logic [DW-1:0] imm, string tag);
        logic [DW-1:0]   nv [WAVE];
        logic [WAVE-1:0] cm;
        int              t;
        do @(negedge clk); while (!in_ready);
        in_valid = 1'b1;
        in_op    = op;
        in_vdst  = VAW'(d);
        in_vsrc0 = VAW'(s0);
        in_vsrc1 = VAW'(s1);
        in_vsrc2 = VAW'(s2);
        in_sdst  = SAW'(sd);
        in_imm   = imm;
        t        = cyc;
        cm       = '0;
        for (int l = 0; l < WAVE; l++) begin
            logic [DW-1:0] a, b, c;
            logic [DW:0]   s;
            a = mdl[s0][l];
            b = mdl[s1][l];
            c = mdl[s2][l];
            case (op)
                OP_SEED: nv[l] = imm + DW'(l);
                OP_ADD:  nv[l] = a + b;
                OP_MAD:  nv[l] = a * b + c;
                default: begin
                    s     = {1'b0, a} + {1'b0, b};
                    nv[l] = s[DW-1:0];
                    cm[l] = s[DW];
                end
            endcase
        end
        for (int l = 0; l < WAVE; l++) mdl[d][l] = nv[l];
        for (int g = 0; g < NGROUP; g++) begin
            wb_exp_t e;
            e.due = t + 3 + g;
            e.grp = g;
            e.dst = d;
            e.tag = tag;
            for (int i = 0; i < QL; i++) e.data[i*DW +: DW] = nv[g*QL + i];
            wq.push_back(e);
        end
        if (op == OP_ADDC) begin
            sc_exp_t s;
            s.due  = t + 7;
            s.dst  = sd;
            s.mask = cm;
            s.tag  = tag;
            sq.push_back(s);
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL R3: watchdog expired, got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R11: quiet outputs during reset
        repeat (3) @(negedge clk);
        chk(in_ready == 1'b0, "R11", "ready in reset", GW'(in_ready), '0);
        chk(wb_valid == 1'b0, "R11", "writeback in reset", GW'(wb_valid), '0);
        chk(sc_valid == 1'b0, "R11", "scalar request in reset", GW'(sc_valid), '0);
        rst = 1'b0;
        #1;
        chk(in_ready == 1'b1, "R1", "first ready after reset", GW'(in_ready), GW'(1));
        mon_on = 1'b1;
        // R1: cadence one in four
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            chk(in_ready == ((k % 4) == 0), "R1", "ready cadence", GW'(in_ready),
                GW'((k % 4) == 0));
        end

        // R5 seeds
        issue(OP_SEED, 0, 0, 0, 0, 0, 32'd3, "R5");
        issue(OP_SEED, 1, 0, 0, 0, 0, 32'd100, "R5");
        issue(OP_SEED, 2, 0, 0, 0, 0, 32'hFFFF_FFF8, "R5");
        issue(OP_SEED, 3, 0, 0, 0, 0, 32'd0, "R5");
        // R6, R7
        issue(OP_ADD, 4, 0, 1, 0, 0, 32'd0, "R6");
        issue(OP_MAD, 5, 1, 0, 4, 0, 32'd0, "R7");
        issue(OP_ADD, 6, 2, 5, 0, 0, 32'd0, "R6");
        // R8: mixed carries (lanes 0..3 no carry), then another mask
        issue(OP_ADDC, 6, 2, 3, 0, 7, 32'd0, "R8");
        issue(OP_ADDC, 7, 4, 2, 0, 3, 32'd0, "R8");
        issue(OP_ADD, 1, 7, 6, 0, 0, 32'd0, "R9");
        // R4: dependent chain on one register at full rate
        for (int k = 0; k < 4; k++) issue(OP_MAD, 0, 0, 0, 0, 0, 32'd0, "R4");
        issue(OP_ADD, 2, 0, 0, 0, 0, 32'd0, "R4");
        issue(OP_ADDC, 2, 2, 2, 0, 15, 32'd0, "R4");
        // R10: idle slot, then in_valid only while ready is low
        do @(negedge clk); while (!in_ready);
        for (int k = 0; k < NGROUP - 1; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_op    = OP_SEED;
            in_vdst  = VAW'(5);
            in_imm   = 32'd999;
        end
        @(negedge clk);
        in_valid = 1'b0;
        issue(OP_ADD, 6, 5, 5, 0, 0, 32'd0, "R10");
        repeat (12) @(negedge clk);
        chk(wq.size() == 0, "R3", "writebacks outstanding", GW'(wq.size()), '0);
        chk(sq.size() == 0, "R8", "masks outstanding", GW'(sq.size()), '0);
        chk(stray_sc == 0, "R9", "stray scalar requests", GW'(stray_sc), '0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule